// File: doc/BRIEF.md
# Serial LSB-First CRC-32 Engine

This block keeps a 32-bit cyclic redundancy check over a serial debug bit stream, one bit per qualified clock. The bits arrive in the same order they travel on the wire, least significant bit of each word first. The engine shifts right and applies the reflected polynomial 0xEDB88320, so it needs no bit reordering. It serves both directions of a debug link. On transmit, the running register value is appended to the stream. On receive, the checksum that follows the data is collected and compared.

A burst begins with a clear, which presets the register to all ones. Each data bit is then presented with a valid strobe. Words of 8 or 16 bits contribute only their own bits. After the last data bit, the link raises the check-mode input and shifts in the 32 received checksum bits. These bits fill a separate capture register and leave the running CRC untouched. A match flag reports whether the captured value equals the computed one. No final inversion or reversal is applied anywhere: the register value is the checksum.

Top module: `crc_serial_unit`

## Requirements
- R1: While synchronous reset is sampled high, the next cycle shows `crcOut` = 0xFFFFFFFF and `crcMatch` = 0, and the capture count is emptied.
- R2: With `bitValid`=1, `checkMode`=0 and `clear`=0 at an edge, let f = `bitIn` XOR `crcOut[0]`. The new `crcOut` is the old value shifted right by one with a 0 entering bit 31, then XORed with 0xEDB88320 when f is 1.
- R3: In any cycle with `bitValid`=0 and `clear`=0, `crcOut` holds its value whatever `bitIn` and `checkMode` do.
- R4: `clear`=1 at an edge reloads `crcOut` to 0xFFFFFFFF and empties the capture register and its count in that one cycle. This takes priority over a simultaneous valid bit in either mode.
- R5: Feeding the nine ASCII bytes "123456789" after a clear, each byte least significant bit first and 8 bits per byte, leaves `crcOut` = 0x340BC6D9.
- R6: With `checkMode`=1, a valid bit never changes `crcOut`. Instead it enters the capture register from the top (bit 31), so the first captured bit ends up in bit 0 after 32 bits.
- R7: `crcMatch` is 1 exactly when at least 32 bits have been captured since the last clear or reset and the captured value equals `crcOut`. It is 0 after only 31 bits, and 0 when any captured bit differs.
- R8: Once 32 bits have been captured, further valid bits in check mode are ignored until the next clear. The capture register keeps its value, so `crcMatch` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Start-of-burst preset strobe |
| bitValid | input | 1 | Qualifies `bitIn` for this cycle |
| bitIn | input | 1 | Serial bit, LSB of each word first |
| checkMode | input | 1 | 1: valid bits are received checksum bits; 0: data bits |
| crcOut | output | 32 | Running CRC register |
| crcMatch | output | 1 | Captured checksum equals running CRC |

## Verification
The assertions check several behaviours on every cycle: holding without a strobe, the preset after clear or reset, the freeze of the CRC in check mode, the single-bit update rule, and that the match flag only rises on a qualified bit. Other behaviours need the bench's scenarios. These are the known "123456789" value, the exact count of 32 captured bits needed for a match, the rejection of one flipped checksum bit, and the discarding of bits beyond the 32nd. The bench reaches them with directed sequences, mixed with seeded random traffic that is compared against a bench model of the register.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;
  typedef struct packed {
    logic loadSeed;  // preset CRC, empty capture path
    logic advance;   // fold one data bit into the CRC
    logic capture;   // shift one received checksum bit in
  } crcStrobes_t;
endpackage

// File: rtl/crc_serial_ctrl.sv
module crc_serial_ctrl
  import crc_serial_pkg::*;
#(
  parameter int W = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        bitValid,
  input  logic        checkMode,
  output crcStrobes_t strobes,
  output logic        rxFull
);
  localparam int CNT_W = $clog2(W + 1);

  logic [CNT_W-1:0] rxCount;

  assign rxFull = (rxCount == CNT_W'(W));

  always_comb begin
    strobes.loadSeed = rst | clear;
    strobes.advance  = bitValid & ~checkMode & ~strobes.loadSeed;
    strobes.capture  = bitValid & checkMode & ~strobes.loadSeed & ~rxFull;
  end

  always_ff @(posedge clk) begin
    if (strobes.loadSeed) begin
      rxCount <= '0;
    end else if (strobes.capture) begin
      rxCount <= rxCount + 1'b1;
    end
  end
endmodule

// File: rtl/crc_serial_dp.sv
module crc_serial_dp
  import crc_serial_pkg::*;
#(
  parameter int         W    = 32,
  parameter logic [W-1:0] POLY = 32'hEDB88320,
  parameter logic [W-1:0] SEED = 32'hFFFFFFFF
) (
  input  logic         clk,
  input  crcStrobes_t  strobes,
  input  logic         bitIn,
  input  logic         rxFull,
  output logic [W-1:0] crcValue,
  output logic         match
);
  logic [W-1:0] crcReg;
  logic [W-1:0] rxReg;
  logic [W-1:0] nextCrc;
  logic         feedback;

  assign feedback = bitIn ^ crcReg[0];

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W - 1) begin : g_top
      assign nextCrc[i] = feedback & POLY[i];
    end else begin : g_low
      assign nextCrc[i] = crcReg[i+1] ^ (feedback & POLY[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.loadSeed) begin
      crcReg <= SEED;
      rxReg  <= '0;
    end else begin
      if (strobes.advance) crcReg <= nextCrc;
      if (strobes.capture) rxReg <= {bitIn, rxReg[W-1:1]};
    end
  end

  assign crcValue = crcReg;
  assign match    = rxFull & (rxReg == crcReg);
endmodule

// File: rtl/crc_serial_unit.sv
module crc_serial_unit
  import crc_serial_pkg::*;
#(
  parameter int           W    = 32,
  parameter logic [W-1:0] POLY = 32'hEDB88320,
  parameter logic [W-1:0] SEED = 32'hFFFFFFFF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         bitValid,
  input  logic         bitIn,
  input  logic         checkMode,
  output logic [W-1:0] crcOut,
  output logic         crcMatch
);
  crcStrobes_t strobes;
  logic        rxFull;

  crc_serial_ctrl #(.W(W)) i_ctrl (
    .clk(clk), .rst(rst), .clear(clear), .bitValid(bitValid),
    .checkMode(checkMode), .strobes(strobes), .rxFull(rxFull)
  );

  crc_serial_dp #(.W(W), .POLY(POLY), .SEED(SEED)) i_dp (
    .clk(clk), .strobes(strobes), .bitIn(bitIn), .rxFull(rxFull),
    .crcValue(crcOut), .match(crcMatch)
  );
endmodule

// File: rtl/crc_serial_chk.sv
module crc_serial_chk #(
  parameter int           W    = 32,
  parameter logic [W-1:0] POLY = 32'hEDB88320,
  parameter logic [W-1:0] SEED = 32'hFFFFFFFF
) (
  input logic         clk,
  input logic         rst,
  input logic         clear,
  input logic         bitValid,
  input logic         bitIn,
  input logic         checkMode,
  input logic [W-1:0] crcOut,
  input logic         crcMatch
);
  // R1
  reset_preset_chk: assert property (@(posedge clk)
    rst |=> (crcOut == SEED) && !crcMatch);

  // R2
  bit_update_chk: assert property (@(posedge clk) disable iff (rst)
    (bitValid && !checkMode && !clear) |=>
      crcOut == (($past(crcOut) >> 1) ^
                 (($past(bitIn) ^ $past(crcOut[0])) ? POLY : '0)));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!bitValid && !clear) |=> $stable(crcOut));

  // R4
  clear_preset_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (crcOut == SEED) && !crcMatch);

  // R6
  check_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (bitValid && checkMode && !clear) |=> $stable(crcOut));

  // R7
  match_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(crcMatch) |-> $past(bitValid && !clear));
endmodule

bind crc_serial_unit crc_serial_chk #(.W(W), .POLY(POLY), .SEED(SEED)) i_chk (
  .clk(clk), .rst(rst), .clear(clear), .bitValid(bitValid), .bitIn(bitIn),
  .checkMode(checkMode), .crcOut(crcOut), .crcMatch(crcMatch)
);

// File: tb/test_crc_serial_unit.sv
module test_crc_serial_unit;
  localparam logic [31:0] POLY = 32'hEDB88320;
  localparam logic [31:0] SEED = 32'hFFFFFFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clear = 1'b0;
  logic bitValid = 1'b0;
  logic bitIn = 1'b0;
  logic checkMode = 1'b0;
  logic [31:0] crcOut;
  logic        crcMatch;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [31:0] mCrc = SEED;
  logic [31:0] mRx = '0;
  int mCnt = 0;

  always #4 clk = ~clk;  // 125 MHz

  crc_serial_unit i_crc_serial_unit (
    .clk(clk), .rst(rst), .clear(clear), .bitValid(bitValid), .bitIn(bitIn),
    .checkMode(checkMode), .crcOut(crcOut), .crcMatch(crcMatch)
  );

  function automatic logic [31:0] crcNext(logic [31:0] c, logic b);
    logic f;
    f = b ^ c[0];
    c = c >> 1;
    if (f) c = c ^ POLY;
    return c;
  endfunction

  task automatic expectVal(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic checkModel(string tag);
    logic expMatch;
    expMatch = (mCnt >= 32) && (mRx == mCrc);
    expectVal(tag, crcOut, mCrc);
    expectVal(tag, {31'd0, crcMatch}, {31'd0, expMatch});
  endtask

  task automatic drive(logic v, logic b, logic m, logic c, string tag);
    @(negedge clk);
    bitValid = v; bitIn = b; checkMode = m; clear = c;
    @(posedge clk);
    #2;
    if (c) begin
      mCrc = SEED; mRx = '0; mCnt = 0;
    end else if (v && !m) begin
      mCrc = crcNext(mCrc, b);
    end else if (v && m && mCnt < 32) begin
      mRx = {b, mRx[31:1]}; mCnt++;
    end
    checkModel(tag);
  endtask

  task automatic sendWord(logic [31:0] w, int nbits, string tag);
    for (int i = 0; i < nbits; i++) drive(1'b1, w[i], 1'b0, 1'b0, tag);
  endtask

  task automatic sendCheck(logic [31:0] w, int nbits, string tag);
    for (int i = 0; i < nbits; i++) drive(1'b1, w[i], 1'b1, 1'b0, tag);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [31:0] w;
    logic [31:0] saved;
    void'($urandom(32'd4242));
    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    expectVal("R1 reset crc", crcOut, SEED);
    expectVal("R1 reset match", {31'd0, crcMatch}, 32'd0);
    @(negedge clk); rst = 1'b0;

    // R5: known check string, byte-wide words LSB first
    drive(0, 0, 0, 1, "R4 clear");
    for (int k = 0; k < 9; k++) sendWord(32'(8'h31 + k), 8, "R5 bytes");
    expectVal("R5 check value", crcOut, 32'h340BC6D9);

    // R3: no strobe, garbage on other inputs
    saved = crcOut;
    for (int k = 0; k < 6; k++) drive(0, k[0], k[1], 0, "R3 idle hold");
    expectVal("R3 held value", crcOut, saved);

    // R2: 16-bit word only its own bits
    sendWord(32'h0000A5C3, 16, "R2 16-bit word");

    // R6/R7: correct checksum, 31 bits then 32nd
    w = mCrc;
    sendCheck(w, 31, "R6 capture");
    expectVal("R7 partial no match", {31'd0, crcMatch}, 32'd0);
    sendCheck(w >> 31, 1, "R7 last bit");
    expectVal("R7 full match", {31'd0, crcMatch}, 32'd1);
    expectVal("R6 crc frozen", crcOut, w);

    // R8: extra bits ignored
    sendCheck(32'hFFFF_FFFF ^ w, 8, "R8 extra bits");
    expectVal("R8 match kept", {31'd0, crcMatch}, 32'd1);

    // R4: clear wins over simultaneous valid in both modes
    drive(1, 1, 0, 1, "R4 clear vs data");
    expectVal("R4 preset", crcOut, SEED);
    sendWord(32'hDEADBEEF, 32, "R2 32-bit word");
    drive(1, 1, 1, 1, "R4 clear vs capture");
    expectVal("R4 preset again", crcOut, SEED);

    // R7: one flipped checksum bit
    sendWord(32'h12345678, 32, "R2 word");
    sendCheck(mCrc ^ 32'h0000_0100, 32, "R7 flipped bit");
    expectVal("R7 mismatch", {31'd0, crcMatch}, 32'd0);

    // R1: reset while dirty
    @(negedge clk); rst = 1'b1; bitValid = 1'b1; clear = 1'b0;
    @(posedge clk); #2;
    mCrc = SEED; mRx = '0; mCnt = 0;
    checkModel("R1 reset mid-run");
    @(negedge clk); rst = 1'b0; bitValid = 1'b0;

    // Random traffic: R2 R3 R4 R6 R7 R8
    for (int k = 0; k < 3000; k++) begin
      drive(($urandom % 4) != 0, $urandom % 2, ($urandom % 4) == 0,
            ($urandom % 32) == 0, "R2 random");
    end
    finish();
  end
endmodule